// File: doc/BRIEF.md
# CAN Receive Mailbox Allocator

This block holds a bank of message mailboxes for a CAN controller and decides where each received frame is kept. A frame receiver hands it fully decoded frames (identifier, extended flag, remote flag, length code and eight payload bytes) as single-cycle pulses. The block stores each frame in the lowest-numbered mailbox that is set up for reception, whose acceptance filter matches the frame, and that is free.

Software reaches the bank through a simple register port. A write port sets a mailbox's mode, acceptance identifier or acceptance mask. A read port returns the status word, identifier word and two data words of any mailbox. A vector of ready flags, one bit per mailbox, shows which mailboxes hold an unread frame. Writing a bitmask on the re-arm input clears those flags and frees the mailboxes for new frames.

One mailbox can be placed in overwrite mode so that it always takes a frame. When it replaces an unread frame it records the loss. A frame that no mailbox will take is dropped, and a sticky overflow output is raised.

Top module: `canrx_mbox_bank`

## Requirements
- R1: After reset every mailbox is disabled and free, every ready bit is 0 and the overflow output is 0.
- R2: The mode of a mailbox is written from bits 26:24 of the write data. Only mode 1 (plain receive) and mode 2 (receive with overwrite) take frames. Mode 0 (off), mode 3 (transmit), mode 4 (consumer), mode 5 (producer) and the codes 6 and 7 never take a frame.
- R3: Each accepted frame goes to exactly one mailbox: the lowest-numbered one that is receive-capable, matches the filter and may accept it.
- R4: A full mailbox in mode 1 is skipped, and its stored frame is left unchanged.
- R5: A mailbox in mode 2 takes a frame even when it is full. If it was full, the message-lost flag (status bit 24) is set. Storing into an empty mailbox clears that flag, and so does re-arming the mailbox.
- R6: The status word puts ready at bit 23, the remote flag at bit 20 and the length code at bits 19:16. Data byte k arrives on frame data bits 8k+7:8k. The low data word returns bytes 0 to 3 and the high data word returns bytes 4 to 7, each byte at the same bit position.
- R7: An identifier word has the extended flag at bit 29. A standard 11-bit ID sits at bits 28:18 and an extended 29-bit ID at bits 28:0. Storing a frame writes the frame's identifier word into the mailbox's identifier register.
- R8: A frame is accepted when its identifier word and the stored identifier agree on every bit set in the 30-bit mask. An all-zero mask accepts every frame.
- R9: A cycle with arm_valid clears the ready and lost flags of every mailbox set in arm_mask. A frame that arrives in the same cycle is placed using the flags as they were before that cycle.
- R10: Bit i of mb_ready is the ready flag of mailbox i, and it sets only in the cycle after a frame is stored.
- R11: A frame that no mailbox takes is dropped and rx_overflow is set. rx_overflow stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_mb | input | 4 | Mailbox selected for the write |
| wr_sel | input | 2 | Register to write: 0 mode, 1 mask, 2 identifier |
| wr_data | input | 32 | Write data |
| arm_valid | input | 1 | Re-arm command strobe |
| arm_mask | input | 16 | Mailboxes to re-arm |
| frm_valid | input | 1 | Decoded frame present, one cycle |
| frm_ide | input | 1 | Frame uses an extended identifier |
| frm_id | input | 29 | Frame identifier; a standard ID sits in bits 10:0 |
| frm_rtr | input | 1 | Remote request frame |
| frm_dlc | input | 4 | Length code |
| frm_data | input | 64 | Payload, byte k at bits 8k+7:8k |
| rd_mb | input | 4 | Mailbox selected for reading |
| rd_status | output | 32 | Status word of the selected mailbox |
| rd_id | output | 32 | Identifier word of the selected mailbox |
| rd_data_lo | output | 32 | Payload bytes 0 to 3 |
| rd_data_hi | output | 32 | Payload bytes 4 to 7 |
| mb_ready | output | 16 | Ready flag of every mailbox |
| rx_overflow | output | 1 | Sticky flag for a dropped frame |

## Verification
The assertions check, on every cycle, that a frame never lands in more than one mailbox and never overwrites a full plain-receive mailbox. They also check that re-armed ready flags fall, that a ready flag rises only after a frame arrives, and that the overflow flag rises only for an unplaced frame and never falls. Only the bench scenarios can show that the chosen mailbox is the lowest eligible one. The same holds for the layout of the status, identifier and data words, the results of the filter for standard and extended identifiers, the mode codes that are refused, and the rule that a same-cycle re-arm and frame use the old flags.

// File: rtl/canrx_pkg.sv
package canrx_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned IDW_W    = 30;
  localparam int unsigned EXT_ID_W = 29;
  localparam int unsigned STD_ID_W = 11;
  localparam int unsigned DLC_W    = 4;
  localparam int unsigned DATA_W   = 64;
  localparam int unsigned MODE_W   = 3;

  localparam int unsigned MODE_LSB   = 24;
  localparam int unsigned ST_LOST    = 24;
  localparam int unsigned ST_READY   = 23;
  localparam int unsigned ST_RTR     = 20;
  localparam int unsigned ST_DLC_LSB = 16;
  localparam int unsigned STD_LSB    = 18;

  localparam logic [MODE_W-1:0] MODE_OFF    = 3'd0;
  localparam logic [MODE_W-1:0] MODE_RX     = 3'd1;
  localparam logic [MODE_W-1:0] MODE_RX_OVW = 3'd2;

  typedef enum logic [1:0] {
    SEL_MODE = 2'd0,
    SEL_MASK = 2'd1,
    SEL_ID   = 2'd2
  } reg_sel_e;

  function automatic logic takes_frames(input logic [MODE_W-1:0] m);
    return (m == MODE_RX) || (m == MODE_RX_OVW);
  endfunction
endpackage

// File: rtl/canrx_accept_filter.sv
module canrx_accept_filter
  import canrx_pkg::*;
#(
  parameter int unsigned NUM_MB = 16
) (
  input  logic [MODE_W-1:0] mb_mode [NUM_MB],
  input  logic [IDW_W-1:0]  mb_id   [NUM_MB],
  input  logic [IDW_W-1:0]  mb_mask [NUM_MB],
  input  logic [NUM_MB-1:0] mb_full,
  input  logic [IDW_W-1:0]  frm_word,
  output logic [NUM_MB-1:0] eligible,
  output logic [NUM_MB-1:0] ovw_vec
);
  for (genvar i = 0; i < NUM_MB; i++) begin : g_flt
    logic hit;
    assign hit         = (((frm_word ^ mb_id[i]) & mb_mask[i]) == '0);
    assign ovw_vec[i]  = (mb_mode[i] == MODE_RX_OVW);
    assign eligible[i] = takes_frames(mb_mode[i]) && hit && (!mb_full[i] || ovw_vec[i]);
  end
endmodule

// File: rtl/canrx_lowest_pick.sv
module canrx_lowest_pick #(
  parameter int unsigned N = 16
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);
  assign grant = req & (~req + {{(N-1){1'b0}}, 1'b1});
  assign any   = |req;
endmodule

// File: rtl/canrx_mbox_store.sv
module canrx_mbox_store
  import canrx_pkg::*;
#(
  parameter int unsigned NUM_MB = 16,
  localparam int unsigned MB_W  = $clog2(NUM_MB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [MB_W-1:0]   wr_mb,
  input  logic [1:0]        wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              arm_valid,
  input  logic [NUM_MB-1:0] arm_mask,
  input  logic [NUM_MB-1:0] store_hot,
  input  logic [IDW_W-1:0]  frm_word,
  input  logic              frm_rtr,
  input  logic [DLC_W-1:0]  frm_dlc,
  input  logic [DATA_W-1:0] frm_data,
  output logic [MODE_W-1:0] mode_q [NUM_MB],
  output logic [IDW_W-1:0]  id_q   [NUM_MB],
  output logic [IDW_W-1:0]  mask_q [NUM_MB],
  output logic [NUM_MB-1:0] ready_q,
  output logic [NUM_MB-1:0] lost_q,
  output logic [NUM_MB-1:0] rtr_q,
  output logic [DLC_W-1:0]  dlc_q  [NUM_MB],
  output logic [DATA_W-1:0] data_q [NUM_MB]
);
  for (genvar i = 0; i < NUM_MB; i++) begin : g_mb
    logic              wr_hit, arm_hit;
    logic [MODE_W-1:0] mode_n;
    logic [IDW_W-1:0]  id_n, mask_n;
    logic              ready_n, lost_n, rtr_n;
    logic [DLC_W-1:0]  dlc_n;
    logic [DATA_W-1:0] data_n;
    logic              upd_en;

    assign wr_hit  = wr_en && (wr_mb == MB_W'(i));
    assign arm_hit = arm_valid && arm_mask[i];
    assign upd_en  = wr_hit || arm_hit || store_hot[i];

    always_comb begin
      mode_n  = mode_q[i];
      id_n    = id_q[i];
      mask_n  = mask_q[i];
      ready_n = ready_q[i];
      lost_n  = lost_q[i];
      rtr_n   = rtr_q[i];
      dlc_n   = dlc_q[i];
      data_n  = data_q[i];
      if (wr_hit) begin
        case (wr_sel)
          SEL_MODE: mode_n = wr_data[MODE_LSB +: MODE_W];
          SEL_MASK: mask_n = wr_data[IDW_W-1:0];
          SEL_ID:   id_n   = wr_data[IDW_W-1:0];
          default:  ;
        endcase
      end
      if (arm_hit) begin
        ready_n = 1'b0;
        lost_n  = 1'b0;
      end
      if (store_hot[i]) begin
        ready_n = 1'b1;
        lost_n  = ready_q[i] && !arm_hit;
        id_n    = frm_word;
        rtr_n   = frm_rtr;
        dlc_n   = frm_dlc;
        data_n  = frm_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mode_q[i]  <= MODE_OFF;
        id_q[i]    <= '0;
        mask_q[i]  <= '0;
        ready_q[i] <= 1'b0;
        lost_q[i]  <= 1'b0;
        rtr_q[i]   <= 1'b0;
        dlc_q[i]   <= '0;
        data_q[i]  <= '0;
      end else if (upd_en) begin
        mode_q[i]  <= mode_n;
        id_q[i]    <= id_n;
        mask_q[i]  <= mask_n;
        ready_q[i] <= ready_n;
        lost_q[i]  <= lost_n;
        rtr_q[i]   <= rtr_n;
        dlc_q[i]   <= dlc_n;
        data_q[i]  <= data_n;
      end
    end
  end
endmodule

// File: rtl/canrx_mbox_bank.sv
module canrx_mbox_bank
  import canrx_pkg::*;
#(
  parameter int unsigned NUM_MB = 16,
  localparam int unsigned MB_W  = $clog2(NUM_MB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [MB_W-1:0]   wr_mb,
  input  logic [1:0]        wr_sel,
  input  logic [31:0]       wr_data,
  input  logic              arm_valid,
  input  logic [NUM_MB-1:0] arm_mask,
  input  logic              frm_valid,
  input  logic              frm_ide,
  input  logic [28:0]       frm_id,
  input  logic              frm_rtr,
  input  logic [3:0]        frm_dlc,
  input  logic [63:0]       frm_data,
  input  logic [MB_W-1:0]   rd_mb,
  output logic [31:0]       rd_status,
  output logic [31:0]       rd_id,
  output logic [31:0]       rd_data_lo,
  output logic [31:0]       rd_data_hi,
  output logic [NUM_MB-1:0] mb_ready,
  output logic              rx_overflow
);
  logic [MODE_W-1:0] mode_q [NUM_MB];
  logic [IDW_W-1:0]  id_q   [NUM_MB];
  logic [IDW_W-1:0]  mask_q [NUM_MB];
  logic [NUM_MB-1:0] ready_q, lost_q, rtr_q;
  logic [DLC_W-1:0]  dlc_q  [NUM_MB];
  logic [DATA_W-1:0] data_q [NUM_MB];

  logic [IDW_W-1:0]  frm_word;
  logic [NUM_MB-1:0] eligible, ovw_vec, grant, store_hot;
  logic              placed;
  logic              ovf_n;

  assign frm_word = frm_ide ? {1'b1, frm_id}
                            : {1'b0, frm_id[STD_ID_W-1:0], {STD_LSB{1'b0}}};

  canrx_accept_filter #(.NUM_MB(NUM_MB)) u_filter (
    .mb_mode (mode_q),
    .mb_id   (id_q),
    .mb_mask (mask_q),
    .mb_full (ready_q),
    .frm_word(frm_word),
    .eligible(eligible),
    .ovw_vec (ovw_vec)
  );

  canrx_lowest_pick #(.N(NUM_MB)) u_pick (
    .req  (eligible),
    .grant(grant),
    .any  (placed)
  );

  assign store_hot = frm_valid ? grant : '0;

  canrx_mbox_store #(.NUM_MB(NUM_MB)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_mb    (wr_mb),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .arm_valid(arm_valid),
    .arm_mask (arm_mask),
    .store_hot(store_hot),
    .frm_word (frm_word),
    .frm_rtr  (frm_rtr),
    .frm_dlc  (frm_dlc),
    .frm_data (frm_data),
    .mode_q   (mode_q),
    .id_q     (id_q),
    .mask_q   (mask_q),
    .ready_q  (ready_q),
    .lost_q   (lost_q),
    .rtr_q    (rtr_q),
    .dlc_q    (dlc_q),
    .data_q   (data_q)
  );

  always_comb begin
    ovf_n = rx_overflow || (frm_valid && !placed);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_overflow <= 1'b0;
    end else if (frm_valid) begin
      rx_overflow <= ovf_n;
    end
  end

  always_comb begin
    rd_status = '0;
    rd_status[ST_LOST]                = lost_q[rd_mb];
    rd_status[ST_READY]               = ready_q[rd_mb];
    rd_status[ST_RTR]                 = rtr_q[rd_mb];
    rd_status[ST_DLC_LSB +: DLC_W]    = dlc_q[rd_mb];
    rd_id      = {{(WORD_W-IDW_W){1'b0}}, id_q[rd_mb]};
    rd_data_lo = data_q[rd_mb][31:0];
    rd_data_hi = data_q[rd_mb][63:32];
  end

  assign mb_ready = ready_q;
endmodule

// File: rtl/canrx_mbox_bank_chk.sv
module canrx_mbox_bank_chk #(
  parameter int unsigned NUM_MB = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frm_valid,
  input logic              arm_valid,
  input logic [NUM_MB-1:0] arm_mask,
  input logic [NUM_MB-1:0] mb_ready,
  input logic              rx_overflow,
  input logic [NUM_MB-1:0] store_hot,
  input logic [NUM_MB-1:0] ovw_vec
);
  a_r3_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(store_hot));

  a_r4_full_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (store_hot & mb_ready & ~ovw_vec) == '0);

  a_r9_arm_clears: assert property (@(posedge clk) disable iff (!rst_n)
    arm_valid |=> ((mb_ready & $past(arm_mask) & ~$past(store_hot)) == '0));

  a_r10_ready_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
    ((mb_ready & ~$past(mb_ready)) != '0) |-> $past(frm_valid));

  a_r11_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overflow |=> rx_overflow);

  a_r11_overflow_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_overflow) |-> ($past(frm_valid) && ($past(store_hot) == '0)));
endmodule

bind canrx_mbox_bank canrx_mbox_bank_chk #(.NUM_MB(NUM_MB)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frm_valid  (frm_valid),
  .arm_valid  (arm_valid),
  .arm_mask   (arm_mask),
  .mb_ready   (mb_ready),
  .rx_overflow(rx_overflow),
  .store_hot  (store_hot),
  .ovw_vec    (ovw_vec)
);

// File: tb/canrx_mbox_bank_bench.sv
module canrx_mbox_bank_bench;
  localparam int NUM_MB = 16;
  localparam int VW = 1 + 29 + 1 + 4 + 64 + 4 + 16 + 1;
  localparam int NV = 6;
  // fields: ide, id, rtr, dlc, data, expected mailbox, expected ready vector, expected lost
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b0, 29'h123,      1'b0, 4'd8,  64'h8877665544332211, 4'd0, 16'h0001, 1'b0},
    {1'b1, 29'h1ABCDEF,  1'b1, 4'd2,  64'hDEADBEEF000000A5, 4'd1, 16'h0003, 1'b0},
    {1'b0, 29'h7FF,      1'b0, 4'd0,  64'h0000000000000001, 4'd2, 16'h0007, 1'b0},
    {1'b1, 29'h1FFFFFFF, 1'b0, 4'd15, 64'hFFEEDDCCBBAA9988, 4'd3, 16'h000F, 1'b0},
    {1'b0, 29'h001,      1'b0, 4'd4,  64'h0102030405060708, 4'd5, 16'h002F, 1'b0},
    {1'b1, 29'h0000ABC,  1'b0, 4'd1,  64'h1111111122222222, 4'd5, 16'h002F, 1'b1}
  };

  logic clk, rst_n;
  logic wr_en; logic [3:0] wr_mb; logic [1:0] wr_sel; logic [31:0] wr_data;
  logic arm_valid; logic [15:0] arm_mask;
  logic frm_valid, frm_ide, frm_rtr; logic [28:0] frm_id; logic [3:0] frm_dlc;
  logic [63:0] frm_data;
  logic [3:0] rd_mb;
  logic [31:0] rd_status, rd_id, rd_data_lo, rd_data_hi;
  logic [15:0] mb_ready;
  logic rx_overflow;
  int checks = 0, errors = 0;

  canrx_mbox_bank u_canrx_mbox_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mb(wr_mb), .wr_sel(wr_sel),
    .wr_data(wr_data), .arm_valid(arm_valid), .arm_mask(arm_mask),
    .frm_valid(frm_valid), .frm_ide(frm_ide), .frm_id(frm_id), .frm_rtr(frm_rtr),
    .frm_dlc(frm_dlc), .frm_data(frm_data), .rd_mb(rd_mb), .rd_status(rd_status),
    .rd_id(rd_id), .rd_data_lo(rd_data_lo), .rd_data_hi(rd_data_hi),
    .mb_ready(mb_ready), .rx_overflow(rx_overflow)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] mb, input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_mb = mb; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_mode(input logic [3:0] mb, input logic [2:0] m);
    wr(mb, 2'd0, {5'b0, m, 24'b0});
  endtask

  task automatic send(input logic ide, input logic [28:0] id, input logic rtr,
                      input logic [3:0] dlc, input logic [63:0] d,
                      input logic av, input logic [15:0] am);
    @(negedge clk);
    frm_valid = 1'b1; frm_ide = ide; frm_id = id; frm_rtr = rtr;
    frm_dlc = dlc; frm_data = d; arm_valid = av; arm_mask = am;
    @(negedge clk);
    frm_valid = 1'b0; arm_valid = 1'b0; arm_mask = '0;
  endtask

  task automatic arm(input logic [15:0] am);
    @(negedge clk);
    arm_valid = 1'b1; arm_mask = am;
    @(negedge clk);
    arm_valid = 1'b0; arm_mask = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_mb = '0; wr_sel = '0; wr_data = '0;
    arm_valid = 1'b0; arm_mask = '0; frm_valid = 1'b0; frm_ide = 1'b0;
    frm_id = '0; frm_rtr = 1'b0; frm_dlc = '0; frm_data = '0; rd_mb = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 ready", {16'b0, mb_ready}, 32'h0);
    check("R1 overflow", {31'b0, rx_overflow}, 32'h0);
    check("R1 status", rd_status, 32'h0);
    // R1: disabled after reset, so a frame is dropped
    send(1'b0, 29'h10, 1'b0, 4'd1, 64'h0, 1'b0, 16'h0);
    check("R1 no mailbox enabled", {16'b0, mb_ready}, 32'h0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int m = 0; m < 4; m++) set_mode(4'(m), 3'd1);
    set_mode(4'd4, 3'd4);
    set_mode(4'd5, 3'd2);
    set_mode(4'd6, 3'd3);
    set_mode(4'd7, 3'd7);

    // R3 R4 R5 R6 R7 R10: vector table
    for (int v = 0; v < NV; v++) begin
      logic [VW-1:0] e;
      logic [31:0] exp_st, exp_id;
      e = VEC[v];
      send(e[119], e[118:90], e[89], e[88:85], e[84:21], 1'b0, 16'h0);
      rd_mb = e[20:17];
      #1;
      exp_st = ({31'b0, e[0]} << 24) | (32'h1 << 23) | ({31'b0, e[89]} << 20)
             | ({28'b0, e[88:85]} << 16);
      exp_id = e[119] ? {3'b001, e[118:90]} : ({21'b0, e[100:90]} << 18);
      check("R10 R3 ready vector", {16'b0, mb_ready}, {16'b0, e[16:1]});
      check("R6 R5 status word", rd_status, exp_st);
      check("R7 id word", rd_id, exp_id);
      check("R6 data low", rd_data_lo, e[52:21]);
      check("R6 data high", rd_data_hi, e[84:53]);
    end
    // R4: mailbox 0 kept its first frame
    rd_mb = 4'd0; #1;
    check("R4 full mailbox unchanged", rd_data_lo, 32'h44332211);
    check("R11 no overflow yet", {31'b0, rx_overflow}, 32'h0);

    // R9 R5: re-arm all
    arm(16'hFFFF);
    rd_mb = 4'd5; #1;
    check("R9 ready cleared", {16'b0, mb_ready}, 32'h0);
    check("R5 lost cleared by rearm", rd_status, 32'h00010000);

    // R8: filter on mailbox 0 only
    set_mode(4'd1, 3'd0); set_mode(4'd2, 3'd0); set_mode(4'd3, 3'd0);
    set_mode(4'd5, 3'd0);
    wr(4'd0, 2'd1, 32'h3FFC0000);
    wr(4'd0, 2'd2, 32'h04000000);
    send(1'b0, 29'h101, 1'b0, 4'd0, 64'h0, 1'b0, 16'h0);
    check("R8 mismatch rejected", {16'b0, mb_ready}, 32'h0);
    check("R11 overflow set", {31'b0, rx_overflow}, 32'h1);
    send(1'b0, 29'h100, 1'b0, 4'd0, 64'h0, 1'b0, 16'h0);
    check("R8 match accepted", {16'b0, mb_ready}, 32'h1);
    check("R11 overflow sticky", {31'b0, rx_overflow}, 32'h1);
    arm(16'h0001);
    send(1'b1, 29'h100, 1'b0, 4'd0, 64'h0, 1'b0, 16'h0);
    check("R8 extended flag compared", {16'b0, mb_ready}, 32'h0);
    send(1'b0, 29'h100, 1'b0, 4'd0, 64'h0, 1'b0, 16'h0);

    // R9 R4: same-cycle re-arm uses old flags
    set_mode(4'd1, 3'd1);
    send(1'b0, 29'h100, 1'b0, 4'd3, 64'h0, 1'b1, 16'h0001);
    check("R9 same-cycle rearm", {16'b0, mb_ready}, 32'h2);
    send(1'b0, 29'h100, 1'b0, 4'd3, 64'h0, 1'b0, 16'h0);
    check("R9 freed mailbox reused", {16'b0, mb_ready}, 32'h3);
    rd_mb = 4'd0; #1;
    check("R7 stored standard id", rd_id, 32'h04000000);

    // R2: modes 3,4,7 never take frames
    send(1'b0, 29'h555, 1'b0, 4'd3, 64'h0, 1'b0, 16'h0);
    check("R2 non-receive modes refuse", {16'b0, mb_ready}, 32'h3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule